// File: doc/BRIEF.md
# Standby Entry and Wake Controller

This block decides when a small processor system may stop its oscillator and all of its clocks, and how it comes back. A sleep strobe taken while the standby-select bit is set parks the system with the oscillator off and every clock gated. The stop is refused while the watchdog is running, and a one-cycle flag reports the refusal. On entry, a one-cycle reset strobe goes to the serial, CAN and synchronous-serial peripherals, because their state is not kept across the stop.

Two things can end the stop. An NMI, or an IRQ line that is allowed to wake the system, turns the oscillator back on. The clocks then stay gated for a settling count chosen by a 5-bit code, and after that an interrupt-exception start pulse is issued. Driving the reset pin low turns the oscillator and the clocks back on in the same cycle. The rising edge of the reset pin then issues a reset-exception start pulse. All counting runs on an always-on reference clock. Register decoding and interrupt priority are outside the block, so they arrive as plain inputs.

Top module: `stby_ctrl`

## Requirements
- R1: In the running state, a `sleep_req` taken with `stby_sel`=1 and `wdt_run`=0 drives `osc_en`=0 and `clk_en`=0 from the next cycle. A `sleep_req` taken with `stby_sel`=0 changes no output.
- R2: A `sleep_req` taken with `stby_sel`=1 while `wdt_run`=1 leaves `clk_en`=1 and `osc_en`=1. It raises `sleep_refused` for exactly the next cycle.
- R3: `periph_rst` is high for exactly the first cycle of standby and is low at all other times.
- R4: In standby, `nmi`=1 wakes the block. So does `irq[i]`=1 when `irq_wake_en[i]`=1, `irq_cpu_mask[i]`=0 and `irq_dma_src[i]`=0. On a wake, `osc_en` goes to 1 in the next cycle while `clk_en` stays 0.
- R5: In standby, an `irq[i]` whose enable bit is 0, whose mask bit is 1 or whose DMA-source bit is 1 does not wake the block, and `osc_en` stays 0.
- R6: After an interrupt wake, `osc_en`=1 and `clk_en`=0 hold for exactly N = 2^(min(code,SAT_CODE)+BASE_EXP) cycles. `clk_en` then goes to 1.
- R7: `irq_exc_start` is high for exactly the first cycle in which `clk_en` returns after the settling count. After that cycle the block is running again.
- R8: The settling code is taken at standby entry. Changing `settle_code` during standby or settling does not change N.
- R9: `res_pin_n`=0 in any state gives `osc_en`=1 and `clk_en`=1 from the next cycle, with no settling count and with `irq_exc_start`=0.
- R10: A high `res_pin_n` in the reset-hold state returns the block to running. It raises `rst_exc_start` for exactly one cycle.
- R11: While `rst_n` is low, and straight after it, the block is in reset hold: `osc_en`=1, `clk_en`=1, and `irq_exc_start`, `periph_rst` and `sleep_refused` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sleep_req | input | 1 | One-cycle sleep instruction strobe |
| stby_sel | input | 1 | 1 selects standby as the sleep target |
| wdt_run | input | 1 | Watchdog running in watchdog mode |
| settle_code | input | CODE_W | Settling-time code |
| nmi | input | 1 | Non-maskable interrupt request |
| irq | input | N_IRQ | IRQ request lines |
| irq_wake_en | input | N_IRQ | Per-line wake enable |
| irq_cpu_mask | input | N_IRQ | Per-line CPU-side mask |
| irq_dma_src | input | N_IRQ | Per-line DMA activation routing |
| res_pin_n | input | 1 | Active-low external reset pin (synchronous) |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 1 | Global clock enable |
| periph_rst | output | 1 | Reset strobe for the peripherals that lose state |
| irq_exc_start | output | 1 | Interrupt exception start pulse |
| rst_exc_start | output | 1 | Reset exception start pulse |
| sleep_refused | output | 1 | Standby entry refused by the watchdog |

## Verification
Embedded properties check on every cycle the following: the watchdog refusal, that a standby-to-settle step always had a qualified wake source, that the reset pin forces clocks on one cycle later, that the peripheral strobe appears only in standby, and that the settling limit stays frozen while counting. The exact length of the settling window for every code, the saturation above SAT_CODE, and the sampling of the code at entry can only be shown by the bench. The bench sweeps all codes and every qualifier combination on every IRQ line.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_STANDBY,
    ST_SETTLE,
    ST_WAKE_IRQ,
    ST_RESET_HOLD
  } stby_state_e;
endpackage

// File: rtl/stby_wake_qual.sv
module stby_wake_qual #(
  parameter int N_IRQ = 15
) (
  input  logic             nmi,
  input  logic [N_IRQ-1:0] irq,
  input  logic [N_IRQ-1:0] irq_wake_en,
  input  logic [N_IRQ-1:0] irq_cpu_mask,
  input  logic [N_IRQ-1:0] irq_dma_src,
  output logic             wake
);
  logic [N_IRQ-1:0] line_ok;

  // A line wakes only if enabled, unmasked at the CPU and not routed to DMA
  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign line_ok[i] = irq[i] & irq_wake_en[i] & ~irq_cpu_mask[i] & ~irq_dma_src[i];
  end

  assign wake = nmi | (|line_ok);
endmodule

// File: rtl/stby_settle_timer.sv
module stby_settle_timer #(
  parameter int CODE_W   = 5,
  parameter int BASE_EXP = 5,
  parameter int SAT_CODE = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_en,
  input  logic [CODE_W-1:0] code_in,
  input  logic              clr,
  input  logic              run,
  output logic              done
);
  localparam int CNT_W = SAT_CODE + BASE_EXP + 1;
  localparam int EXP_W = $clog2(SAT_CODE + BASE_EXP + 1);

  logic [CODE_W-1:0] sat_code;
  logic [EXP_W-1:0]  exp_d;
  logic [CNT_W-1:0]  limit_d, limit_q, cnt_q, cnt_d;

  always_comb begin
    sat_code = (code_in > CODE_W'(SAT_CODE)) ? CODE_W'(SAT_CODE) : code_in;
    exp_d    = EXP_W'(sat_code) + EXP_W'(BASE_EXP);
    limit_d  = (CNT_W'(1) << exp_d) - CNT_W'(1);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (latch_en) limit_q <= limit_d;
      if (clr || run) cnt_q <= cnt_d;
    end
  end

  assign done = run && (cnt_q == limit_q);

  // R6: the counter never runs past the limit while settling
  assert_cnt_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit_q));

  // R8: the limit is frozen for the whole settling window
  assert_limit_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(limit_q));
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int N_IRQ    = 15,
  parameter int CODE_W   = 5,
  parameter int BASE_EXP = 5,
  parameter int SAT_CODE = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              stby_sel,
  input  logic              wdt_run,
  input  logic [CODE_W-1:0] settle_code,
  input  logic              nmi,
  input  logic [N_IRQ-1:0]  irq,
  input  logic [N_IRQ-1:0]  irq_wake_en,
  input  logic [N_IRQ-1:0]  irq_cpu_mask,
  input  logic [N_IRQ-1:0]  irq_dma_src,
  input  logic              res_pin_n,
  output logic              osc_en,
  output logic              clk_en,
  output logic              periph_rst,
  output logic              irq_exc_start,
  output logic              rst_exc_start,
  output logic              sleep_refused
);
  stby_state_e st_q, st_d;
  logic wake, tmr_done;
  logic enter_d, start_d, refuse_d, rst_go_d;
  logic periph_q, refuse_q, rst_go_q;

  stby_wake_qual #(.N_IRQ(N_IRQ)) u_qual (
    .nmi          (nmi),
    .irq          (irq),
    .irq_wake_en  (irq_wake_en),
    .irq_cpu_mask (irq_cpu_mask),
    .irq_dma_src  (irq_dma_src),
    .wake         (wake)
  );

  stby_settle_timer #(
    .CODE_W   (CODE_W),
    .BASE_EXP (BASE_EXP),
    .SAT_CODE (SAT_CODE)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_en (enter_d),
    .code_in  (settle_code),
    .clr      (start_d),
    .run      (st_q == ST_SETTLE),
    .done     (tmr_done)
  );

  // next-state logic; the reset pin overrides every state
  always_comb begin
    st_d     = st_q;
    enter_d  = 1'b0;
    start_d  = 1'b0;
    refuse_d = 1'b0;
    rst_go_d = 1'b0;
    if (!res_pin_n) begin
      st_d = ST_RESET_HOLD;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (sleep_req && stby_sel) begin
            if (wdt_run) begin
              refuse_d = 1'b1;
            end else begin
              st_d    = ST_STANDBY;
              enter_d = 1'b1;
            end
          end
        end
        ST_STANDBY: begin
          if (wake) begin
            st_d    = ST_SETTLE;
            start_d = 1'b1;
          end
        end
        ST_SETTLE: begin
          if (tmr_done) st_d = ST_WAKE_IRQ;
        end
        ST_WAKE_IRQ: st_d = ST_RUN;
        ST_RESET_HOLD: begin
          st_d     = ST_RUN;
          rst_go_d = 1'b1;
        end
        default: st_d = ST_RESET_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RESET_HOLD;
      periph_q <= 1'b0;
      refuse_q <= 1'b0;
      rst_go_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      periph_q <= enter_d;
      refuse_q <= refuse_d;
      rst_go_q <= rst_go_d;
    end
  end

  assign osc_en        = (st_q != ST_STANDBY);
  assign clk_en        = (st_q == ST_RUN) || (st_q == ST_WAKE_IRQ) || (st_q == ST_RESET_HOLD);
  assign irq_exc_start = (st_q == ST_WAKE_IRQ);
  assign periph_rst    = periph_q;
  assign rst_exc_start = rst_go_q;
  assign sleep_refused = refuse_q;

  // R2: a running watchdog blocks entry and flags the refusal
  assert_wdt_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && res_pin_n && sleep_req && stby_sel && wdt_run)
      |=> (clk_en && sleep_refused));

  // R3: the peripheral strobe appears only while parked
  assert_periph_in_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> (!osc_en && !clk_en));

  // R5: leaving standby for settling always had a qualified source
  assert_qualified_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETTLE && $past(st_q) == ST_STANDBY)
      |-> $past(nmi || (|(irq & irq_wake_en & ~irq_cpu_mask & ~irq_dma_src))));

  // R9: the reset pin brings clocks on one cycle later without settling
  assert_pin_clocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_pin_n |=> (osc_en && clk_en && !irq_exc_start));

  // R10: the reset exception pulse lasts one cycle
  assert_rst_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_exc_start |=> !rst_exc_start);
endmodule

// File: tb/sim_stby_ctrl.sv
module sim_stby_ctrl;
  localparam int N_IRQ = 15;
  localparam int CODE_W = 5;
  localparam int BASE_EXP = 1;
  localparam int SAT_CODE = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic sleep_req, stby_sel, wdt_run, nmi, res_pin_n;
  logic [CODE_W-1:0] settle_code;
  logic [N_IRQ-1:0] irq, irq_wake_en, irq_cpu_mask, irq_dma_src;
  logic osc_en, clk_en, periph_rst, irq_exc_start, rst_exc_start, sleep_refused;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  stby_ctrl #(
    .N_IRQ(N_IRQ), .CODE_W(CODE_W), .BASE_EXP(BASE_EXP), .SAT_CODE(SAT_CODE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_sel(stby_sel),
    .wdt_run(wdt_run), .settle_code(settle_code), .nmi(nmi), .irq(irq),
    .irq_wake_en(irq_wake_en), .irq_cpu_mask(irq_cpu_mask),
    .irq_dma_src(irq_dma_src), .res_pin_n(res_pin_n), .osc_en(osc_en),
    .clk_en(clk_en), .periph_rst(periph_rst), .irq_exc_start(irq_exc_start),
    .rst_exc_start(rst_exc_start), .sleep_refused(sleep_refused)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int settle_len(input int code);
    int c;
    c = (code > SAT_CODE) ? SAT_CODE : code;
    return 1 << (c + BASE_EXP);
  endfunction

  task automatic go_standby(input int code);
    settle_code = CODE_W'(code);
    sleep_req = 1'b1;
    stby_sel = 1'b1;
    tick();
    sleep_req = 1'b0;
    check("R1 osc off", int'(osc_en), 0);
    check("R1 clk off", int'(clk_en), 0);
    check("R3 strobe", int'(periph_rst), 1);
    tick();
    check("R3 strobe end", int'(periph_rst), 0);
  endtask

  // counts gated cycles with the oscillator on; ends in the first clock-on cycle
  task automatic count_settle(output int n);
    n = 0;
    while (osc_en && !clk_en && n < 400) begin
      n++;
      tick();
    end
  endtask

  task automatic pin_reset(input string tag);
    res_pin_n = 1'b0;
    tick();
    check({tag, " R9 osc"}, int'(osc_en), 1);
    check({tag, " R9 clk"}, int'(clk_en), 1);
    check({tag, " R9 no irq start"}, int'(irq_exc_start), 0);
    res_pin_n = 1'b1;
    tick();
    check({tag, " R10 pulse"}, int'(rst_exc_start), 1);
    tick();
    check({tag, " R10 pulse end"}, int'(rst_exc_start), 0);
    check({tag, " R10 running"}, int'(clk_en), 1);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int n;
    int exp_wake;
    rst_n = 1'b0;
    sleep_req = 0; stby_sel = 0; wdt_run = 0; nmi = 0; res_pin_n = 1;
    settle_code = '0; irq = '0; irq_wake_en = '0; irq_cpu_mask = '0; irq_dma_src = '0;
    @(negedge clk);
    @(negedge clk);
    check("R11 osc in reset", int'(osc_en), 1);
    check("R11 clk in reset", int'(clk_en), 1);
    check("R11 irq start", int'(irq_exc_start), 0);
    check("R11 periph", int'(periph_rst), 0);
    check("R11 refused", int'(sleep_refused), 0);
    rst_n = 1'b1;
    tick();
    check("R10 pulse after power-on", int'(rst_exc_start), 1);
    tick();
    check("R10 pulse end", int'(rst_exc_start), 0);

    // R1: sleep without standby select does nothing
    sleep_req = 1; stby_sel = 0;
    tick();
    sleep_req = 0;
    check("R1 no-select osc", int'(osc_en), 1);
    check("R1 no-select clk", int'(clk_en), 1);
    check("R1 no-select periph", int'(periph_rst), 0);

    // R2: watchdog refusal
    wdt_run = 1; sleep_req = 1; stby_sel = 1;
    tick();
    sleep_req = 0;
    check("R2 clk stays", int'(clk_en), 1);
    check("R2 osc stays", int'(osc_en), 1);
    check("R2 refused", int'(sleep_refused), 1);
    check("R2 no strobe", int'(periph_rst), 0);
    tick();
    check("R2 refused end", int'(sleep_refused), 0);
    wdt_run = 0;

    // R6 / R7: every settling code via NMI
    for (int code = 0; code < 32; code++) begin
      go_standby(code);
      check("R1 still parked", int'(osc_en), 0);
      nmi = 1;
      tick();
      nmi = 0;
      check("R4 nmi osc on", int'(osc_en), 1);
      check("R4 nmi clk gated", int'(clk_en), 0);
      count_settle(n);
      check($sformatf("R6 length code %0d", code), n, settle_len(code));
      check("R7 irq start", int'(irq_exc_start), 1);
      tick();
      check("R7 irq start end", int'(irq_exc_start), 0);
      check("R7 running", int'(clk_en), 1);
    end

    // R8: code changed after entry has no effect
    go_standby(2);
    settle_code = 5'd6;
    nmi = 1;
    tick();
    nmi = 0;
    settle_code = 5'd0;
    count_settle(n);
    check("R8 sampled at entry", n, settle_len(2));
    tick();

    // R4 / R5: qualifier sweep on every line
    for (int i = 0; i < N_IRQ; i++) begin
      for (int combo = 0; combo < 8; combo++) begin
        irq_wake_en = '0; irq_cpu_mask = '0; irq_dma_src = '0;
        irq_wake_en[i] = combo[2];
        irq_cpu_mask[i] = combo[1];
        irq_dma_src[i] = combo[0];
        exp_wake = (combo == 4) ? 1 : 0;
        go_standby(0);
        irq[i] = 1'b1;
        tick();
        if (exp_wake == 1) begin
          check($sformatf("R4 line %0d wakes", i), int'(osc_en), 1);
          check("R4 clk gated", int'(clk_en), 0);
          irq = '0;
          count_settle(n);
          check("R6 irq wake length", n, settle_len(0));
          check("R7 irq start", int'(irq_exc_start), 1);
          tick();
        end else begin
          check($sformatf("R5 line %0d combo %0d", i, combo), int'(osc_en), 0);
          tick();
          tick();
          check("R5 still parked", int'(osc_en), 0);
          irq = '0;
          pin_reset("standby");
        end
      end
    end
    irq_wake_en = '0;

    // R9: reset pin during settling and while running
    go_standby(31);
    nmi = 1;
    tick();
    nmi = 0;
    tick();
    tick();
    check("R9 mid-settle gated", int'(clk_en), 0);
    pin_reset("settle");
    pin_reset("run");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule